// File: doc/BRIEF.md
# Task-File Register Decoder for an I/O-Mapped Flash Card

This block sits behind the host bus of a removable flash card that runs in I/O-mapped mode. On every host read or write strobe it decodes the I/O address and the two active-low card enables. From these it picks one task-file register and decides which byte lanes carry the transfer. For the 16-bit data port it also tracks whether the next byte access is the even half or the odd half.

The command block sits at 1F0h..1F7h and the control pair at 3F6h..3F7h. Many offsets name different registers for reads and for writes. For example, the read-only error, status and drive-address values come in as inputs from the command engine, while feature, command and device-control values written by the host are presented as outputs. The data port can be moved as one word or as two ordered bytes. One enable pattern at offset 0 reaches the error/feature byte and leaves the data port alone.

Everything is sampled on the internal clock. A read drives the bus one clock after the strobe is first seen low. A write commits on the first clock that sees its strobe high again, using the address, enables and data held from the last clock the strobe was low.

Top module: `cf_taskfile_dec`

## Requirements
- R1: Only addresses whose bits 9..4 equal 1Fh with bit 3 clear, or 3F6h/3F7h, are decoded. Any other address is not driven on a read and changes no register on a write.
- R2: Byte reads at offsets 1 and 7 of the command block return `err_in` and `stat_in`. Offsets 2..6 return the stored sector count, sector number, cylinder low, cylinder high and card/head bytes.
- R3: Byte writes at offsets 1..7 of the command block store, in order, feature, sector count, sector number, cylinder low, cylinder high, card/head and command. Feature appears on `feature_o`, command on `command_o`, and offsets 2..6 read back the written value.
- R4: A read at 3F6h returns `stat_in`. A write at 3F6h stores the byte on `devctl_o`.
- R5: A read at 3F7h returns `drv_addr_in`. A write at 3F7h changes nothing.
- R6: With both enables low at offset 0 or 1 of the command block (A0 ignored), the access is one 16-bit data word on D15..D0, and `rd_lane_en` is 2'b11.
- R7: With `ce1_n` low and `ce2_n` high at offset 0, data moves one byte at a time on D7..D0. The first byte is the low (even) half of the data word and the second is the high (odd) half.
- R8: With `ce1_n` high and `ce2_n` low at offset 0, a read returns `err_in` on D15..D8 and a write stores D15..D8 as feature. Neither touches the data word or the even/odd phase.
- R9: The even/odd phase returns to even on reset and after any word access to the data port.
- R10: A non-data byte access with `ce1_n` low uses D7..D0 at the addressed offset. With only `ce2_n` low it uses D15..D8 at the odd offset (A0 forced to 1). With both enables high nothing is decoded.
- R11: `rd_lane_en` is 2'b01 for the low lane, 2'b10 for the high lane, 2'b11 for a word, and 2'b00 (with `rd_data` zero) whenever no decoded read is being served. This includes the cycles of a write.
- R12: A write takes effect on the first clock that sees its strobe high again. Reset clears every stored register and the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 10 | Host I/O address A9..A0 |
| ce1_n | input | 1 | Active-low even-byte card enable |
| ce2_n | input | 1 | Active-low odd-byte card enable |
| iord_n | input | 1 | Active-low I/O read strobe |
| iowr_n | input | 1 | Active-low I/O write strobe |
| wr_data | input | 16 | Host write data D15..D0 |
| err_in | input | 8 | Error byte from the command engine |
| stat_in | input | 8 | Status byte from the command engine |
| drv_addr_in | input | 8 | Drive-address byte from the command engine |
| rd_data | output | 16 | Registered read data, zero when not driven |
| rd_lane_en | output | 2 | Output enables: bit 0 for D7..D0, bit 1 for D15..D8 |
| feature_o | output | 8 | Stored feature byte |
| command_o | output | 8 | Stored command byte |
| devctl_o | output | 8 | Stored device-control byte |

## Verification
The hardest state to reach is a byte-mode data transfer stopped halfway, with the phase sitting on the odd half, and then an odd-lane access to offset 0 slipped in. To get there, the stimulus fills the data word with two byte writes and reads one byte back. It then issues an error read and a feature write with only `ce2_n` low, and checks that the next byte read still returns the odd half. Word reads placed between byte reads, and a reset taken while the phase is odd, confirm that the phase returns to even.

// File: rtl/cf_tf_pkg.sv
package cf_tf_pkg;

  // Register selected by a decoded access; read/write meaning depends on direction.
  // SEL_ERRFEAT..SEL_STATCMD follow command-block offsets 1..7 in order.
  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_DATA,
    SEL_ERRFEAT,
    SEL_SECCNT,
    SEL_SECNUM,
    SEL_CYLLO,
    SEL_CYLHI,
    SEL_HEAD,
    SEL_STATCMD,
    SEL_ALTCTL,
    SEL_DRVRSV
  } tf_sel_e;

  typedef enum logic [1:0] {
    LANE_NONE,
    LANE_LO,
    LANE_HI,
    LANE_WORD
  } tf_lane_e;

endpackage

// File: rtl/cf_tf_addr_dec.sv
module cf_tf_addr_dec
  import cf_tf_pkg::*;
#(
  parameter int              BLK_W   = 6,
  parameter logic [BLK_W-1:0] CMD_BLK = 6'h1F,
  parameter logic [BLK_W-1:0] CTL_BLK = 6'h3F,
  localparam int             AW      = BLK_W + 4
) (
  input  logic [AW-1:0] addr,
  input  logic          ce1_n,
  input  logic          ce2_n,
  output tf_sel_e       sel,
  output tf_lane_e      lane
);

  logic       cmd_hit;
  logic       ctl_hit;
  logic [2:0] off;

  assign cmd_hit = (addr[AW-1 -: BLK_W] == CMD_BLK) && !addr[3];
  assign ctl_hit = (addr[AW-1 -: BLK_W] == CTL_BLK) && (addr[3:1] == 3'b011);

  always_comb begin
    sel  = SEL_NONE;
    lane = LANE_NONE;
    off  = addr[2:0];
    case ({ce1_n, ce2_n})
      2'b00: begin
        if (cmd_hit && addr[2:1] == 2'b00) begin
          sel  = SEL_DATA;
          lane = LANE_WORD;
        end else begin
          lane = LANE_LO;
        end
      end
      2'b01:   lane = LANE_LO;
      2'b10: begin
        lane = LANE_HI;
        off  = {addr[2:1], 1'b1};
      end
      default: lane = LANE_NONE;
    endcase

    if (lane != LANE_NONE && sel == SEL_NONE) begin
      if (cmd_hit) begin
        sel = tf_sel_e'({1'b0, off} + 4'd1);
      end else if (ctl_hit) begin
        sel = off[0] ? SEL_DRVRSV : SEL_ALTCTL;
      end else begin
        lane = LANE_NONE;
      end
    end
  end

endmodule

// File: rtl/cf_tf_byte_phase.sv
module cf_tf_byte_phase
  import cf_tf_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     done,
  input  tf_sel_e  done_sel,
  input  tf_lane_e done_lane,
  output logic     odd
);

  logic byte_done;
  logic word_done;

  assign byte_done = done && done_sel == SEL_DATA && done_lane == LANE_LO;
  assign word_done = done && done_sel == SEL_DATA && done_lane == LANE_WORD;

  always_ff @(posedge clk) begin
    if (rst) begin
      odd <= 1'b0;
    end else if (word_done) begin
      odd <= 1'b0;
    end else if (byte_done) begin
      odd <= ~odd;
    end
  end

  // R7
  byte_flip_chk: assert property (@(posedge clk) disable iff (rst)
    byte_done |=> odd != $past(odd));

  // R9
  word_even_chk: assert property (@(posedge clk) disable iff (rst)
    word_done |=> !odd);

endmodule

// File: rtl/cf_tf_regfile.sv
module cf_tf_regfile
  import cf_tf_pkg::*;
#(
  parameter  int DW   = 16,
  parameter  int NREG = 7,
  localparam int BW   = DW / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  tf_sel_e       w_sel,
  input  tf_lane_e      w_lane,
  input  logic [DW-1:0] w_data,
  input  logic          phase_odd,
  input  tf_sel_e       r_sel,
  input  tf_lane_e      r_lane,
  input  logic [BW-1:0] err_in,
  input  logic [BW-1:0] stat_in,
  input  logic [BW-1:0] drv_in,
  output logic [DW-1:0] r_data,
  output logic [BW-1:0] feature_o,
  output logic [BW-1:0] command_o,
  output logic [BW-1:0] devctl_o
);

  // Byte storage indexed by (select - SEL_ERRFEAT): feature, four geometry bytes, head, command.
  logic [BW-1:0] tf_mem [NREG];
  logic [DW-1:0] data_q;
  logic [BW-1:0] devctl_q;
  logic [BW-1:0] w_byte;
  logic [2:0]    w_idx;
  logic [2:0]    r_idx;
  logic [BW-1:0] r_byte;

  assign w_byte = (w_lane == LANE_HI) ? w_data[DW-1:BW] : w_data[BW-1:0];
  assign w_idx  = 3'(w_sel - SEL_ERRFEAT);
  assign r_idx  = 3'(r_sel - SEL_ERRFEAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q   <= '0;
      devctl_q <= '0;
      for (int i = 0; i < NREG; i++) tf_mem[i] <= '0;
    end else if (we) begin
      case (w_sel)
        SEL_DATA: begin
          if (w_lane == LANE_WORD)  data_q <= w_data;
          else if (phase_odd)       data_q[DW-1:BW] <= w_data[BW-1:0];
          else                      data_q[BW-1:0]  <= w_data[BW-1:0];
        end
        SEL_ERRFEAT, SEL_SECCNT, SEL_SECNUM, SEL_CYLLO,
        SEL_CYLHI, SEL_HEAD, SEL_STATCMD:
          tf_mem[w_idx] <= w_byte;
        SEL_ALTCTL: devctl_q <= w_byte;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (r_sel)
      SEL_DATA:                   r_byte = phase_odd ? data_q[DW-1:BW] : data_q[BW-1:0];
      SEL_ERRFEAT:                r_byte = err_in;
      SEL_SECCNT, SEL_SECNUM, SEL_CYLLO,
      SEL_CYLHI, SEL_HEAD:        r_byte = tf_mem[r_idx];
      SEL_STATCMD, SEL_ALTCTL:    r_byte = stat_in;
      SEL_DRVRSV:                 r_byte = drv_in;
      default:                    r_byte = '0;
    endcase
    case (r_lane)
      LANE_WORD: r_data = data_q;
      LANE_LO:   r_data = {{BW{1'b0}}, r_byte};
      LANE_HI:   r_data = {r_byte, {BW{1'b0}}};
      default:   r_data = '0;
    endcase
  end

  assign feature_o = tf_mem[0];
  assign command_o = tf_mem[NREG-1];
  assign devctl_o  = devctl_q;

  // R8
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(we && w_sel == SEL_DATA) |-> $stable(data_q));

endmodule

// File: rtl/cf_taskfile_dec.sv
module cf_taskfile_dec
  import cf_tf_pkg::*;
#(
  parameter  int               BLK_W   = 6,
  parameter  logic [BLK_W-1:0] CMD_BLK = 6'h1F,
  parameter  logic [BLK_W-1:0] CTL_BLK = 6'h3F,
  parameter  int               DW      = 16,
  localparam int               AW      = BLK_W + 4,
  localparam int               BW      = DW / 2,
  localparam int               NLANE   = DW / BW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    io_addr,
  input  logic             ce1_n,
  input  logic             ce2_n,
  input  logic             iord_n,
  input  logic             iowr_n,
  input  logic [DW-1:0]    wr_data,
  input  logic [BW-1:0]    err_in,
  input  logic [BW-1:0]    stat_in,
  input  logic [BW-1:0]    drv_addr_in,
  output logic [DW-1:0]    rd_data,
  output logic [NLANE-1:0] rd_lane_en,
  output logic [BW-1:0]    feature_o,
  output logic [BW-1:0]    command_o,
  output logic [BW-1:0]    devctl_o
);

  tf_sel_e       live_sel, cap_sel;
  tf_lane_e      live_lane, cap_lane;
  logic [DW-1:0] cap_data;
  logic          rd_req, wr_req;
  logic          rd_act_q, wr_act_q;
  logic          rd_done, wr_done;
  logic          phase_odd;
  logic [DW-1:0] rf_rdata;

  assign rd_req  = !iord_n && iowr_n;
  assign wr_req  = !iowr_n && iord_n;
  assign rd_done = rd_act_q && !rd_req;
  assign wr_done = wr_act_q && !wr_req;

  cf_tf_addr_dec #(.BLK_W(BLK_W), .CMD_BLK(CMD_BLK), .CTL_BLK(CTL_BLK)) dec_i (
    .addr  (io_addr),
    .ce1_n (ce1_n),
    .ce2_n (ce2_n),
    .sel   (live_sel),
    .lane  (live_lane)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_act_q <= 1'b0;
      wr_act_q <= 1'b0;
      cap_sel  <= SEL_NONE;
      cap_lane <= LANE_NONE;
      cap_data <= '0;
    end else begin
      rd_act_q <= rd_req;
      wr_act_q <= wr_req;
      if (rd_req || wr_req) begin
        cap_sel  <= live_sel;
        cap_lane <= live_lane;
        cap_data <= wr_data;
      end
    end
  end

  cf_tf_byte_phase phase_i (
    .clk       (clk),
    .rst       (rst),
    .done      (rd_done || wr_done),
    .done_sel  (cap_sel),
    .done_lane (cap_lane),
    .odd       (phase_odd)
  );

  cf_tf_regfile #(.DW(DW)) rf_i (
    .clk       (clk),
    .rst       (rst),
    .we        (wr_done),
    .w_sel     (cap_sel),
    .w_lane    (cap_lane),
    .w_data    (cap_data),
    .phase_odd (phase_odd),
    .r_sel     (live_sel),
    .r_lane    (live_lane),
    .err_in    (err_in),
    .stat_in   (stat_in),
    .drv_in    (drv_addr_in),
    .r_data    (rf_rdata),
    .feature_o (feature_o),
    .command_o (command_o),
    .devctl_o  (devctl_o)
  );

  always_ff @(posedge clk) begin
    if (rst || !rd_req || live_lane == LANE_NONE) begin
      rd_data    <= '0;
      rd_lane_en <= '0;
    end else begin
      rd_data <= rf_rdata;
      case (live_lane)
        LANE_WORD: rd_lane_en <= 2'b11;
        LANE_HI:   rd_lane_en <= 2'b10;
        default:   rd_lane_en <= 2'b01;
      endcase
    end
  end

  // R11
  oe_needs_read_chk: assert property (@(posedge clk) disable iff (rst)
    rd_lane_en != 0 |-> $past(rd_req));

  // R11
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_lane_en == 0 |-> rd_data == 0);

  // R5
  rsv_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_done && cap_sel == SEL_DRVRSV) |=>
      $stable(feature_o) && $stable(command_o) && $stable(devctl_o));

  // R12
  cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_done) |-> $stable(command_o));

endmodule

// File: tb/cf_taskfile_dec_tb.sv
module cf_taskfile_dec_tb_top;

  localparam logic [7:0] ERR_V  = 8'h4E;
  localparam logic [7:0] STAT_V = 8'h50;
  localparam logic [7:0] DRV_V  = 8'hC3;
  localparam int NV = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  io_addr = '0;
  logic        ce1_n = 1'b1, ce2_n = 1'b1;
  logic        iord_n = 1'b1, iowr_n = 1'b1;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [1:0]  rd_lane_en;
  logic [7:0]  feature_o, command_o, devctl_o;

  int n_vec = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #2.5 clk = ~clk;

  cf_taskfile_dec dut_i (
    .clk(clk), .rst(rst), .io_addr(io_addr), .ce1_n(ce1_n), .ce2_n(ce2_n),
    .iord_n(iord_n), .iowr_n(iowr_n), .wr_data(wr_data),
    .err_in(ERR_V), .stat_in(STAT_V), .drv_addr_in(DRV_V),
    .rd_data(rd_data), .rd_lane_en(rd_lane_en),
    .feature_o(feature_o), .command_o(command_o), .devctl_o(devctl_o)
  );

  // {wr, addr[9:0], ce1_n, ce2_n, wdata[15:0], exp[15:0], exp_en[1:0], req[3:0]}
  localparam logic [50:0] VEC [NV] = '{
    {1'b1, 10'h1F2, 2'b01, 16'h00A1, 16'h0000, 2'b00, 4'd3},  // R3
    {1'b1, 10'h1F3, 2'b01, 16'h00B2, 16'h0000, 2'b00, 4'd3},
    {1'b1, 10'h1F4, 2'b01, 16'h00C3, 16'h0000, 2'b00, 4'd3},
    {1'b1, 10'h1F5, 2'b01, 16'h00D4, 16'h0000, 2'b00, 4'd3},
    {1'b1, 10'h1F6, 2'b01, 16'h00E5, 16'h0000, 2'b00, 4'd3},
    {1'b1, 10'h1F1, 2'b01, 16'h0077, 16'h0000, 2'b00, 4'd3},
    {1'b1, 10'h1F7, 2'b01, 16'h0090, 16'h0000, 2'b00, 4'd3},
    {1'b0, 10'h1F2, 2'b01, 16'h0000, 16'h00A1, 2'b01, 4'd3},
    {1'b0, 10'h1F3, 2'b01, 16'h0000, 16'h00B2, 2'b01, 4'd3},
    {1'b0, 10'h1F4, 2'b01, 16'h0000, 16'h00C3, 2'b01, 4'd3},
    {1'b0, 10'h1F5, 2'b01, 16'h0000, 16'h00D4, 2'b01, 4'd3},
    {1'b0, 10'h1F6, 2'b01, 16'h0000, 16'h00E5, 2'b01, 4'd3},
    {1'b0, 10'h1F1, 2'b01, 16'h0000, 16'h004E, 2'b01, 4'd2},  // R2 error
    {1'b0, 10'h1F7, 2'b01, 16'h0000, 16'h0050, 2'b01, 4'd2},  // R2 status
    {1'b0, 10'h3F6, 2'b01, 16'h0000, 16'h0050, 2'b01, 4'd4},  // R4
    {1'b1, 10'h3F6, 2'b01, 16'h0006, 16'h0000, 2'b00, 4'd4},
    {1'b0, 10'h3F7, 2'b01, 16'h0000, 16'h00C3, 2'b01, 4'd5},  // R5
    {1'b1, 10'h1F0, 2'b00, 16'h1234, 16'h0000, 2'b00, 4'd6},  // R6
    {1'b0, 10'h1F0, 2'b00, 16'h0000, 16'h1234, 2'b11, 4'd6},
    {1'b0, 10'h1F1, 2'b00, 16'h0000, 16'h1234, 2'b11, 4'd6},
    {1'b1, 10'h1F0, 2'b01, 16'h00AB, 16'h0000, 2'b00, 4'd7},  // R7 even
    {1'b1, 10'h1F0, 2'b01, 16'h00CD, 16'h0000, 2'b00, 4'd7},  // R7 odd
    {1'b0, 10'h1F0, 2'b00, 16'h0000, 16'hCDAB, 2'b11, 4'd7},
    {1'b0, 10'h1F0, 2'b01, 16'h0000, 16'h00AB, 2'b01, 4'd7},
    {1'b0, 10'h1F0, 2'b10, 16'h0000, 16'h4E00, 2'b10, 4'd8},  // R8 mid-pair
    {1'b0, 10'h1F0, 2'b01, 16'h0000, 16'h00CD, 2'b01, 4'd8},
    {1'b0, 10'h1F0, 2'b01, 16'h0000, 16'h00AB, 2'b01, 4'd9},  // R9
    {1'b0, 10'h1F0, 2'b00, 16'h0000, 16'hCDAB, 2'b11, 4'd9},
    {1'b0, 10'h1F0, 2'b01, 16'h0000, 16'h00AB, 2'b01, 4'd9},
    {1'b1, 10'h1F0, 2'b10, 16'h5A00, 16'h0000, 2'b00, 4'd8},  // R8 feature
    {1'b0, 10'h1F0, 2'b00, 16'h0000, 16'hCDAB, 2'b11, 4'd8},
    {1'b0, 10'h1F3, 2'b10, 16'h0000, 16'hB200, 2'b10, 4'd10}, // R10
    {1'b0, 10'h1F2, 2'b10, 16'h0000, 16'hB200, 2'b10, 4'd10},
    {1'b0, 10'h1F2, 2'b11, 16'h0000, 16'h0000, 2'b00, 4'd10},
    {1'b0, 10'h170, 2'b01, 16'h0000, 16'h0000, 2'b00, 4'd1},  // R1
    {1'b0, 10'h1F8, 2'b01, 16'h0000, 16'h0000, 2'b00, 4'd1},
    {1'b1, 10'h2F2, 2'b01, 16'h00FF, 16'h0000, 2'b00, 4'd1},
    {1'b0, 10'h1F2, 2'b01, 16'h0000, 16'h00A1, 2'b01, 4'd1},
    {1'b1, 10'h1F4, 2'b00, 16'h0037, 16'h0000, 2'b00, 4'd10},
    {1'b0, 10'h1F4, 2'b01, 16'h0000, 16'h0037, 2'b01, 4'd10}
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic io_wr(input logic [9:0] a, input logic [1:0] ce, input logic [15:0] d,
                       input string req);
    @(negedge clk);
    io_addr = a; {ce1_n, ce2_n} = ce; wr_data = d; iowr_n = 1'b0;
    @(negedge clk);
    chk({30'd0, rd_lane_en}, 32'd0, {req, " (R11 no drive during write)"});
    iowr_n = 1'b1;
    @(negedge clk);
    {ce1_n, ce2_n} = 2'b11;
  endtask

  task automatic io_rd(input logic [9:0] a, input logic [1:0] ce, input logic [15:0] exp,
                       input logic [1:0] en, input string req);
    @(negedge clk);
    io_addr = a; {ce1_n, ce2_n} = ce; iord_n = 1'b0;
    @(negedge clk);
    chk({16'd0, rd_data}, {16'd0, exp}, {req, " data"});
    chk({30'd0, rd_lane_en}, {30'd0, en}, {req, " lanes"});
    iord_n = 1'b1;
    @(negedge clk);
    {ce1_n, ce2_n} = 2'b11;
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<=20000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12: reset state
    chk({30'd0, rd_lane_en}, 32'd0, "R12 reset lanes");
    chk({16'd0, rd_data}, 32'd0, "R12 reset data");
    chk({24'd0, command_o}, 32'd0, "R12 reset command");

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i][3:0], i);
      if (VEC[i][50])
        io_wr(VEC[i][49:40], VEC[i][39:38], VEC[i][37:22], tag);
      else
        io_rd(VEC[i][49:40], VEC[i][39:38], VEC[i][21:6], VEC[i][5:4], tag);
    end

    chk({24'd0, feature_o}, 32'h5A, "R8 feature via high lane");
    chk({24'd0, command_o}, 32'h90, "R3 command");
    chk({24'd0, devctl_o},  32'h06, "R4 device control");

    // R5: reserved write leaves every register unchanged
    io_wr(10'h3F7, 2'b01, 16'h00EE, "R5");
    chk({24'd0, feature_o}, 32'h5A, "R5 feature kept");
    chk({24'd0, command_o}, 32'h90, "R5 command kept");
    chk({24'd0, devctl_o},  32'h06, "R5 devctl kept");
    io_rd(10'h1F2, 2'b01, 16'h00A1, 2'b01, "R5 seccnt kept");
    io_rd(10'h1F6, 2'b01, 16'h00E5, 2'b01, "R5 head kept");

    // R12: commit only after the strobe is released
    @(negedge clk);
    io_addr = 10'h1F7; {ce1_n, ce2_n} = 2'b01; wr_data = 16'h0033; iowr_n = 1'b0;
    repeat (3) @(negedge clk);
    chk({24'd0, command_o}, 32'h90, "R12 held while strobe low");
    iowr_n = 1'b1;
    @(negedge clk);
    chk({24'd0, command_o}, 32'h33, "R12 commit on release");
    {ce1_n, ce2_n} = 2'b11;

    // R9: reset with the phase left odd
    io_wr(10'h1F0, 2'b01, 16'h0011, "R9 byte before reset");
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk({24'd0, feature_o}, 32'h0, "R12 feature cleared");
    chk({24'd0, devctl_o},  32'h0, "R12 devctl cleared");
    io_wr(10'h1F0, 2'b01, 16'h0022, "R9 first byte after reset");
    io_rd(10'h1F0, 2'b00, 16'h0022, 2'b11, "R9 even after reset");

    finish_run();
  end

endmodule